// File: doc/BRIEF.md
# Over-Clock Watchdog with Safe Frequency Fallback

This block guards a system whose clock generator may have been pushed past a stable operating point. Software arms it with an enable bit and a timeout measured in coarse time-base units. A free-running prescaler divides the system clock down to one tick per unit. While armed, the block counts these ticks down from the timeout value. The host proves it is alive by sending a kick pulse, which starts the count over.

If the count runs out with no kick, three things happen on the same clock edge:
- A sticky alarm flag is set.
- The 4-bit frequency-select code that leaves the block is replaced by a programmable safe code.
- An open-drain reset request starts one fixed-width pulse that pulls the system reset line low.

While there is no alarm, a source-select input picks the frequency code. It can be the code captured from strap pins during reset, or the code from a register. All register values arrive on parallel ports together with write strobes.

Top module: `overclock_guard`

## Requirements
- R1: While `rst` is high, the block captures `strap_code` and clears the alarm and the reset pulse. Reset also sets the stored timeout to 8 units and the stored safe code to 4'b1111. After reset, changes on `strap_code` have no effect on `freq_code`.
- R2: The prescaler emits one tick every TICK_CYCLES clocks. The first tick falls on the TICK_CYCLES-th rising edge after reset is released. The prescaler runs regardless of enable.
- R3: When `wd_enable` is 1 and there is no kick, the alarm sets on the edge of the N-th tick after the last reload, where N is the stored timeout.
- R4: A `kick` pulse reloads the count from the stored timeout. A `timeout_wr` pulse stores `timeout_din` and reloads the count from it. A write takes priority over a kick in the same cycle.
- R5: A stored timeout of 0 behaves as a timeout of 1 unit.
- R6: While `wd_enable` is 0, the count is held at its reload value, and the alarm neither sets nor changes except through `alarm_clr`.
- R7: The alarm is sticky. Only `alarm_clr` (one cycle later) or reset clears it. If a timeout and `alarm_clr` fall in the same cycle, the timeout wins. No counting takes place while the alarm is set.
- R8: With the alarm clear, `freq_code` equals the captured strap code when `src_sel`=0 and equals `reg_code` when `src_sel`=1. This path is combinational from `src_sel` and `reg_code`.
- R9: With the alarm set, `freq_code` equals the stored safe code. `safe_wr` stores `safe_din`.
- R10: `sysrst_pull_low` (1 = pull the line low, 0 = release) rises on the edge where the alarm sets and stays high for exactly PULSE_CYCLES clocks. A timeout that occurs while a pulse is running does not extend it or start a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; strap capture window |
| wd_enable | input | 1 | 1 = watchdog counts, 0 = held idle |
| kick | input | 1 | Host keep-alive pulse, reloads the count |
| timeout_wr | input | 1 | Store strobe for `timeout_din` |
| timeout_din | input | 8 | Timeout in time-base units |
| safe_wr | input | 1 | Store strobe for `safe_din` |
| safe_din | input | 4 | Fallback frequency code |
| alarm_clr | input | 1 | Clears the sticky alarm |
| src_sel | input | 1 | 0 = strap code, 1 = register code |
| strap_code | input | 4 | Frequency code sampled during reset |
| reg_code | input | 4 | Software frequency code |
| freq_code | output | 4 | Effective frequency-select code |
| alarm | output | 1 | Sticky watchdog alarm status |
| sysrst_pull_low | output | 1 | Open-drain enable: 1 pulls system reset low |

## Verification
The alarm and the start of the reset pulse are registered. They appear on the edge that consumes the final tick, so the tick phase since reset fixes the cycle in which each expiry is due. `freq_code` follows `src_sel` and `reg_code` in the same cycle, and it follows the alarm on that same edge. The bench keeps a cycle-exact reference of prescaler phase, remaining units and pulse length, built from the requirements. It drives inputs on the falling edge and compares every output one nanosecond after each rising edge, when both the registers and the combinational select have settled. Directed cases add explicit bounds: zero timeout within one tick, the default timeout between 7 and 8 ticks, and a pulse width of exactly PULSE_CYCLES.

// File: rtl/ovg_pkg.sv
package ovg_pkg;

    localparam int CODE_W = 4;
    localparam int UNIT_W = 8;

    typedef logic [CODE_W-1:0] fcode_t;
    typedef logic [UNIT_W-1:0] units_t;

    typedef enum logic [1:0] {
        SRC_STRAP = 2'd0,
        SRC_REG   = 2'd1,
        SRC_SAFE  = 2'd2
    } code_src_e;

    typedef struct packed {
        logic   reload;
        units_t value;
    } reload_t;

    function automatic units_t eff_units(input units_t raw);
        return (raw == '0) ? units_t'(1) : raw;
    endfunction

    function automatic code_src_e pick_source(input logic alarm_q, input logic sel);
        if (alarm_q)  return SRC_SAFE;
        else if (sel) return SRC_REG;
        else          return SRC_STRAP;
    endfunction

endpackage

// File: rtl/ovg_tick_gen.sv
module ovg_tick_gen #(
    parameter int TICK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)               phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);
endmodule

// File: rtl/ovg_unit_counter.sv
module ovg_unit_counter
    import ovg_pkg::*;
#(
    parameter int DEF_TIMEOUT = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   wd_enable,
    input  logic   kick,
    input  logic   timeout_wr,
    input  units_t timeout_din,
    input  logic   alarm_clr,
    output logic   alarm,
    output logic   fire
);
    units_t  to_q;
    units_t  remain;
    reload_t rl;

    // reload request and the value it loads; a write wins over a kick
    always_comb begin
        rl.reload = 1'b0;
        rl.value  = eff_units(to_q);
        if (timeout_wr) begin
            rl.reload = 1'b1;
            rl.value  = eff_units(timeout_din);
        end else if (kick || !wd_enable || alarm) begin
            rl.reload = 1'b1;
        end
    end

    assign fire = tick && !rl.reload && (remain == units_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            to_q   <= units_t'(DEF_TIMEOUT);
            remain <= eff_units(units_t'(DEF_TIMEOUT));
            alarm  <= 1'b0;
        end else begin
            if (timeout_wr) to_q <= timeout_din;

            if (rl.reload)  remain <= rl.value;
            else if (fire)  remain <= eff_units(to_q);
            else if (tick)  remain <= remain - 1'b1;

            if (fire)           alarm <= 1'b1;
            else if (alarm_clr) alarm <= 1'b0;
        end
    end
endmodule

// File: rtl/ovg_pulse_gen.sv
module ovg_pulse_gen #(
    parameter int PULSE_CYCLES = 3200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pulse
);
    localparam int CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);

    logic          active;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == LAST) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end
    end

    assign pulse = active;
endmodule

// File: rtl/ovg_code_select.sv
module ovg_code_select
    import ovg_pkg::*;
#(
    parameter logic [3:0] SAFE_DEFAULT = 4'hF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   safe_wr,
    input  fcode_t safe_din,
    input  fcode_t strap_code,
    input  fcode_t reg_code,
    input  logic   src_sel,
    input  logic   alarm,
    output fcode_t safe_q,
    output fcode_t freq_code
);
    fcode_t    strap_q;
    code_src_e src;

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= strap_code;
            safe_q  <= fcode_t'(SAFE_DEFAULT);
        end else if (safe_wr) begin
            safe_q  <= safe_din;
        end
    end

    assign src = pick_source(alarm, src_sel);

    always_comb begin
        unique case (src)
            SRC_SAFE: freq_code = safe_q;
            SRC_REG:  freq_code = reg_code;
            default:  freq_code = strap_q;
        endcase
    end
endmodule

// File: rtl/overclock_guard.sv
module overclock_guard
    import ovg_pkg::*;
#(
    parameter int         TICK_CYCLES  = 1000,
    parameter int         PULSE_CYCLES = 3200,
    parameter int         DEF_TIMEOUT  = 8,
    parameter logic [3:0] SAFE_DEFAULT = 4'hF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_enable,
    input  logic       kick,
    input  logic       timeout_wr,
    input  logic [7:0] timeout_din,
    input  logic       safe_wr,
    input  logic [3:0] safe_din,
    input  logic       alarm_clr,
    input  logic       src_sel,
    input  logic [3:0] strap_code,
    input  logic [3:0] reg_code,
    output logic [3:0] freq_code,
    output logic       alarm,
    output logic       sysrst_pull_low
);
    logic   tick;
    logic   fire;
    fcode_t safe_q;

    ovg_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    ovg_unit_counter #(.DEF_TIMEOUT(DEF_TIMEOUT)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .wd_enable   (wd_enable),
        .kick        (kick),
        .timeout_wr  (timeout_wr),
        .timeout_din (timeout_din),
        .alarm_clr   (alarm_clr),
        .alarm       (alarm),
        .fire        (fire)
    );

    ovg_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .start (fire),
        .pulse (sysrst_pull_low)
    );

    ovg_code_select #(.SAFE_DEFAULT(SAFE_DEFAULT)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .safe_wr    (safe_wr),
        .safe_din   (safe_din),
        .strap_code (strap_code),
        .reg_code   (reg_code),
        .src_sel    (src_sel),
        .alarm      (alarm),
        .safe_q     (safe_q),
        .freq_code  (freq_code)
    );
endmodule

// File: rtl/overclock_guard_chk.sv
module overclock_guard_chk #(
    parameter int PULSE_CYCLES = 3200
) (
    input logic       clk,
    input logic       rst,
    input logic       alarm,
    input logic       alarm_clr,
    input logic       wd_enable,
    input logic       pull,
    input logic       src_sel,
    input logic [3:0] reg_code,
    input logic [3:0] safe_q,
    input logic [3:0] freq_code
);
    localparam int CW = $clog2(PULSE_CYCLES + 2);
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (pull) run <= run + 1'b1;
        else           run <= '0;
    end

    // R10: pulse begins on the edge the alarm rises
    a_r10_pulse_on_alarm: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> pull);

    // R10: pulse never exceeds its width
    a_r10_pulse_width: assert property (@(posedge clk) disable iff (rst)
        run <= CW'(PULSE_CYCLES));

    // R7: alarm is sticky without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        alarm && !alarm_clr |=> alarm);

    // R6: a disabled watchdog cannot change the alarm
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wd_enable && !alarm_clr |=> $stable(alarm));

    // R9: safe code drives the output during alarm
    a_r9_safe_override: assert property (@(posedge clk) disable iff (rst)
        alarm |-> freq_code == safe_q);

    // R8: register code selected when no alarm
    a_r8_reg_select: assert property (@(posedge clk) disable iff (rst)
        !alarm && src_sel |-> freq_code == reg_code);
endmodule

bind overclock_guard overclock_guard_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .alarm     (alarm),
    .alarm_clr (alarm_clr),
    .wd_enable (wd_enable),
    .pull      (sysrst_pull_low),
    .src_sel   (src_sel),
    .reg_code  (reg_code),
    .safe_q    (safe_q),
    .freq_code (freq_code)
);

// File: tb/overclock_guard_tb.sv
`timescale 1ns/1ps
module overclock_guard_tb;
    localparam int TICK  = 4;
    localparam int PULSE = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wd_enable = 0, kick = 0, timeout_wr = 0, safe_wr = 0, alarm_clr = 0, src_sel = 0;
    logic [7:0] timeout_din = 0;
    logic [3:0] safe_din = 0, strap_code = 4'b0101, reg_code = 0;
    logic [3:0] freq_code;
    logic       alarm, sysrst_pull_low;

    int n_cmp = 0, n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    overclock_guard #(.TICK_CYCLES(TICK), .PULSE_CYCLES(PULSE)) u_dut (
        .clk(clk), .rst(rst), .wd_enable(wd_enable), .kick(kick),
        .timeout_wr(timeout_wr), .timeout_din(timeout_din),
        .safe_wr(safe_wr), .safe_din(safe_din), .alarm_clr(alarm_clr),
        .src_sel(src_sel), .strap_code(strap_code), .reg_code(reg_code),
        .freq_code(freq_code), .alarm(alarm), .sysrst_pull_low(sysrst_pull_low)
    );

    // reference model built from the requirements
    int         m_pre;
    int         m_rem;
    int         m_to;
    bit         m_alarm;
    int         m_pcnt;
    bit         m_pact;
    logic [3:0] m_strap, m_safe;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [3:0] exp_freq();
        if (m_alarm)  return m_safe;
        if (src_sel)  return reg_code;
        return m_strap;
    endfunction

    always @(posedge clk) begin
        bit t, fire, rl;
        int rv;
        if (rst) begin
            m_pre <= 0; m_rem <= 8; m_to <= 8; m_alarm <= 0;
            m_pcnt <= 0; m_pact <= 0; m_strap <= strap_code; m_safe <= 4'hF;
        end else begin
            t  = (m_pre == TICK - 1);
            rl = timeout_wr || kick || !wd_enable || m_alarm;
            rv = timeout_wr ? eff(timeout_din) : eff(m_to);
            fire = t && !rl && (m_rem == 1);
            m_pre <= t ? 0 : m_pre + 1;
            if (timeout_wr) m_to <= timeout_din;
            if (rl) m_rem <= rv;
            else if (fire) m_rem <= eff(m_to);
            else if (t) m_rem <= m_rem - 1;
            if (fire) m_alarm <= 1;
            else if (alarm_clr) m_alarm <= 0;
            if (safe_wr) m_safe <= safe_din;
            if (m_pact) begin
                if (m_pcnt == PULSE - 1) begin m_pact <= 0; m_pcnt <= 0; end
                else m_pcnt <= m_pcnt + 1;
            end else if (fire) begin
                m_pact <= 1; m_pcnt <= 0;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, sampled 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            check("R3", "alarm", alarm, m_alarm);
            check("R10", "pull", sysrst_pull_low, m_pact);
            check(m_alarm ? "R9" : "R8", "freq", freq_code, exp_freq());
        end
    end

    task automatic drv();
        @(negedge clk);
    endtask

    task automatic idle_strobes();
        kick = 0; timeout_wr = 0; safe_wr = 0; alarm_clr = 0;
    endtask

    task automatic sample();
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp=0", cycles);
            finish_run();
        end
    end

    // wait for alarm to rise; returns cycles waited (limit if not seen)
    task automatic wait_alarm(input int limit, output int n);
        n = 0;
        while (!alarm && n < limit) begin sample(); n++; end
    endtask

    initial begin
        int n, w;
        void'($urandom(32'h5eed_0042));
        repeat (3) drv();
        rst = 0;
        drv();
        strap_code = 4'b0011;
        sample();
        check("R1", "reset alarm", alarm, 0);
        check("R1", "reset pull", sysrst_pull_low, 0);
        check("R1", "strap captured", freq_code, 4'b0101);
        drv(); src_sel = 1; reg_code = 4'b1010;
        sample();
        check("R8", "reg code", freq_code, 4'b1010);
        drv(); src_sel = 0;

        // R6: disabled for many ticks, no alarm
        repeat (20 * TICK) sample();
        check("R6", "idle no alarm", alarm, 0);

        // R3 / R2: default 8 units
        drv(); wd_enable = 1;
        wait_alarm(20 * TICK, n);
        check("R3", "default expiry lower", int'(n > 7 * TICK), 1);
        check("R2", "default expiry upper", int'(n <= 8 * TICK), 1);
        check("R9", "safe default", freq_code, 4'hF);
        // R10: pulse width
        w = 0;
        while (sysrst_pull_low) begin w++; sample(); end
        check("R10", "pulse width", w, PULSE);
        // R7: sticky, disable does not clear (R6)
        drv(); wd_enable = 0;
        repeat (5 * TICK) sample();
        check("R6", "alarm kept when disabled", alarm, 1);
        check("R7", "sticky", alarm, 1);
        drv(); alarm_clr = 1; drv(); alarm_clr = 0;
        check("R7", "cleared", alarm, 0);

        // R5: zero timeout = one unit
        drv(); wd_enable = 1; timeout_wr = 1; timeout_din = 0;
        drv(); timeout_wr = 0;
        wait_alarm(4 * TICK, n);
        check("R5", "zero timeout within one tick", int'(n < TICK), 1);
        drv(); alarm_clr = 1; safe_wr = 1; safe_din = 4'b0110;
        drv(); idle_strobes();

        // R4: kicks every tick keep alarm away with timeout 3
        timeout_wr = 1; timeout_din = 3; drv(); timeout_wr = 0;
        repeat (30) begin
            repeat (TICK) drv();
            kick = 1; drv(); kick = 0;
        end
        check("R4", "kicked no alarm", alarm, 0);
        wait_alarm(6 * TICK, n);
        check("R9", "new safe code", freq_code, 4'b0110);
        drv(); alarm_clr = 1; drv(); alarm_clr = 0;

        // random phase
        for (int i = 0; i < 4000; i++) begin
            drv();
            idle_strobes();
            wd_enable  = ($urandom_range(0, 19) != 0);
            kick       = ($urandom_range(0, 9) == 0);
            timeout_wr = ($urandom_range(0, 29) == 0);
            timeout_din = 8'($urandom_range(0, 5));
            safe_wr    = ($urandom_range(0, 39) == 0);
            safe_din   = 4'($urandom);
            alarm_clr  = ($urandom_range(0, 24) == 0);
            src_sel    = 1'($urandom);
            reg_code   = 4'($urandom);
            strap_code = 4'($urandom);
        end
        drv(); idle_strobes();
        sample();
        finish_run();
    end
endmodule